// File: doc/BRIEF.md
# Split-Line Code Fetch Unit

This block is the read side of a read-only instruction cache. Each fetch returns a 16-byte window of code that begins at any byte address. The caller presents a byte address. One cycle later the block returns the window in ascending address order, ready for a prefetch queue. Instructions can be up to 15 bytes long, so a window often runs past the end of a cache line. The block handles this by checking the tag of the line that holds the address and the tag of the following line at the same time. It reads the half-line from each, joins the two halves, and shifts the result into order. No second access is needed.

The block stores 32-byte lines in 128 sets of 2 ways. Only the fill port can write the array, and each fill writes one whole line with its check bits. Every 8-byte group carries one parity bit, and each read checks the groups the window actually uses. A third tag port serves snoop lookups and can also invalidate the line it finds. Replacement is least recently used. Both fetch hits and fills update the recency state.

Top module: `sl_fetch_unit`

## Requirements
- R1: After reset, every line is invalid and `win_vld`, `win_hit`, `win_perr` and `snp_hit` are low. A fetch before any fill misses.
- R2: `win_vld` is high in the cycle after a cycle with `fetch_vld` high, and low in the cycle after a cycle with `fetch_vld` low.
- R3: The address splits into byte offset [4:0], set index [11:5] and tag [31:12]. On a hit, byte i of `win_data` (bits 8i+7..8i) is the code byte at `fetch_addr`+i, for i from 0 to 15.
- R4: When the offset is 16 or less, the window lies inside one line. It hits when that line is present, whether or not the next line is present, and it misses when that line is absent.
- R5: When the offset is above 16, the window needs both line N and line N+1. It hits only when both are present. Line N+1 is found by incrementing the line address, so index 127 rolls over to index 0 with the tag increased by one.
- R6: `fill_par[g]` is even parity over bytes 8g..8g+7 of the line: the XOR of those 64 bits and the parity bit is 0. A bad group that the window uses forces `win_hit` low and `win_perr` high. A bad group outside the window has no effect. `win_perr` is only raised when every needed line is present.
- R7: A fill goes to the way that already holds that line if there is one. Otherwise it goes to the lowest-numbered invalid way, and otherwise to the least recently used way. Fetch hits and fills both make the way they touch the most recently used.
- R8: `snp_hit` is high in the cycle after a snoop request whose line is present. With `snp_inv` high, that line is invalidated, so later fetches of it miss.
- R9: A fetch issued in the same cycle as a fill sees the array as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_vld | input | 1 | Fetch request |
| fetch_addr | input | 32 | Byte address of the window start |
| fill_vld | input | 1 | Line fill strobe |
| fill_line | input | 27 | Line address of the fill (byte address bits [31:5]) |
| fill_data | input | 256 | Line contents, byte k at bits 8k+7..8k |
| fill_par | input | 4 | Even parity bit for each 8-byte group |
| snp_vld | input | 1 | Snoop lookup request |
| snp_line | input | 27 | Line address being snooped |
| snp_inv | input | 1 | Invalidate the snooped line if present |
| win_vld | output | 1 | Window response valid |
| win_hit | output | 1 | Every needed line present with good parity |
| win_perr | output | 1 | Parity error in a used group |
| win_data | output | 128 | Aligned window, lowest address in byte 0 |
| snp_hit | output | 1 | Snooped line was present |

## Verification
Fetches at offsets 0, 5, 16, 17, 24 and 31 separate the single-line path from the straddling path and expose any error in the shift amount. Fetches that end exactly at a line end, with the next line absent, show whether the next-line tag is wrongly required. Fetches at offsets above 16 with the next line absent show whether it is wrongly ignored. A straddle from set 127 into set 0 tests the carry from index into tag. Lines with one corrupted group are read through windows that just include or just exclude that group, which checks that the used-group mask ends at the right byte. The sequence fill, fill, touch, fill shows whether the recency state steers the eviction.

// File: rtl/sl_fetch_pkg.sv
`timescale 1ns/1ps
package sl_fetch_pkg;
   // Three tag lookup ports: the fetch line, the following line, and the snoop line.
   localparam int N_TAG_PORTS = 3;

   typedef enum logic [1:0] {
      TP_CUR = 2'd0,
      TP_NXT = 2'd1,
      TP_SNP = 2'd2
   } tag_port_e;

   // Result of one tag lookup: hit flag and the way that matched (at most 2 ways).
   typedef struct packed {
      logic hit;
      logic way;
   } tag_look_t;
endpackage

// File: rtl/sl_tag_array.sv
`timescale 1ns/1ps
module sl_tag_array
   import sl_fetch_pkg::*;
#(
   parameter int SETS  = 128,
   parameter int WAYS  = 2,
   parameter int TAG_W = 20
) (
   input  logic                                   clk,
   input  logic                                   rst,
   input  logic [N_TAG_PORTS-1:0][$clog2(SETS)-1:0] look_idx,
   input  logic [N_TAG_PORTS-1:0][TAG_W-1:0]        look_tag,
   output tag_look_t [N_TAG_PORTS-1:0]              look,
   input  logic                                   fill_en,
   input  logic [$clog2(SETS)-1:0]                fill_idx,
   input  logic [TAG_W-1:0]                       fill_tag,
   output logic                                   fill_way,
   input  logic                                   inv_en,
   input  logic [$clog2(SETS)-1:0]                inv_idx,
   input  logic                                   inv_way,
   input  logic [1:0]                             touch_en,
   input  logic [1:0][$clog2(SETS)-1:0]           touch_idx,
   input  logic [1:0]                             touch_way
);
   localparam int IDX_W = $clog2(SETS);

   logic [SETS-1:0]  vld_q [WAYS];
   logic [TAG_W-1:0] tag_q [WAYS][SETS];
   logic             victim;

   // Parallel lookup ports.
   for (genvar p = 0; p < N_TAG_PORTS; p++) begin : g_port
      tag_look_t res;
      always_comb begin
         res = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (vld_q[w][look_idx[p]] && (tag_q[w][look_idx[p]] == look_tag[p])) begin
               res.hit = 1'b1;
               res.way = 1'(w);
            end
         end
      end
      assign look[p] = res;
   end

   // Fill way choice: matching way, else lowest invalid way, else victim.
   logic fill_match, fill_free;
   logic fill_mway, fill_fway;
   always_comb begin
      fill_match = 1'b0;
      fill_mway  = 1'b0;
      fill_free  = 1'b0;
      fill_fway  = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[w][fill_idx] && (tag_q[w][fill_idx] == fill_tag)) begin
            fill_match = 1'b1;
            fill_mway  = 1'(w);
         end
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_q[w][fill_idx]) begin
            fill_free = 1'b1;
            fill_fway = 1'(w);
         end
      end
      if (fill_match)     fill_way = fill_mway;
      else if (fill_free) fill_way = fill_fway;
      else                fill_way = victim;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      end else begin
         if (inv_en) vld_q[inv_way][inv_idx] <= 1'b0;
         if (fill_en) begin
            vld_q[fill_way][fill_idx] <= 1'b1;
            tag_q[fill_way][fill_idx] <= fill_tag;
         end
      end
   end

   // Replacement variant chosen by associativity.
   if (WAYS == 2) begin : g_lru
      logic [SETS-1:0] mru_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            mru_q <= '0;
         end else begin
            for (int t = 0; t < 2; t++)
               if (touch_en[t]) mru_q[touch_idx[t]] <= touch_way[t];
            if (fill_en) mru_q[fill_idx] <= fill_way;
         end
      end
      assign victim = ~mru_q[fill_idx];
   end else begin : g_direct
      logic unused_touch;
      assign unused_touch = ^{touch_en, touch_idx, touch_way, IDX_W[0]};
      assign victim       = 1'b0;
   end
endmodule

// File: rtl/sl_line_store.sv
`timescale 1ns/1ps
module sl_line_store #(
   parameter int SETS       = 128,
   parameter int WAYS       = 2,
   parameter int LINE_BYTES = 32,
   parameter int PAR_BYTES  = 8
) (
   input  logic                                         clk,
   input  logic                                         wr_en,
   input  logic [$clog2(SETS)-1:0]                      wr_idx,
   input  logic                                         wr_way,
   input  logic [LINE_BYTES*8-1:0]                      wr_data,
   input  logic [LINE_BYTES/PAR_BYTES-1:0]              wr_par,
   input  logic [1:0][$clog2(SETS)-1:0]                 rd_idx,
   input  logic [1:0]                                   rd_way,
   input  logic [1:0]                                   rd_half,
   output logic [1:0][LINE_BYTES*4-1:0]                 rd_data,
   output logic [1:0][LINE_BYTES/PAR_BYTES/2-1:0]       rd_err
);
   localparam int LINE_BITS = LINE_BYTES * 8;
   localparam int HALF_BITS = LINE_BITS / 2;
   localparam int NGRP      = LINE_BYTES / PAR_BYTES;
   localparam int HGRP      = NGRP / 2;
   localparam int GRP_BITS  = PAR_BYTES * 8;

   logic [LINE_BITS-1:0] data_q [WAYS][SETS];
   logic [NGRP-1:0]      par_q  [WAYS][SETS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_q[wr_way][wr_idx] <= wr_data;
         par_q[wr_way][wr_idx]  <= wr_par;
      end
   end

   // Two half-line read ports, each recomputing parity of its groups.
   for (genvar p = 0; p < 2; p++) begin : g_rd
      logic [LINE_BITS-1:0] line;
      logic [NGRP-1:0]      par;
      assign line = data_q[rd_way[p]][rd_idx[p]];
      assign par  = par_q[rd_way[p]][rd_idx[p]];
      always_comb begin
         int base;
         base = rd_half[p] ? HGRP : 0;
         rd_data[p] = rd_half[p] ? line[LINE_BITS-1 -: HALF_BITS] : line[HALF_BITS-1:0];
         for (int g = 0; g < HGRP; g++)
            rd_err[p][g] = (^line[(base + g) * GRP_BITS +: GRP_BITS]) ^ par[base + g];
      end
   end
endmodule

// File: rtl/sl_window_align.sv
`timescale 1ns/1ps
module sl_window_align #(
   parameter int HALF_BYTES = 16,
   parameter int PAR_BYTES  = 8,
   parameter bit STAGED     = 1'b1
) (
   input  logic [HALF_BYTES*8-1:0]            lo_data,
   input  logic [HALF_BYTES*8-1:0]            hi_data,
   input  logic [HALF_BYTES/PAR_BYTES-1:0]    lo_err,
   input  logic [HALF_BYTES/PAR_BYTES-1:0]    hi_err,
   input  logic [$clog2(HALF_BYTES)-1:0]      shift,
   output logic [HALF_BYTES*8-1:0]            win,
   output logic                               bad
);
   localparam int HALF_BITS = HALF_BYTES * 8;
   localparam int CAT_BITS  = 2 * HALF_BITS;
   localparam int SH_W      = $clog2(HALF_BYTES);
   localparam int HGRP      = HALF_BYTES / PAR_BYTES;

   logic [CAT_BITS-1:0] cat, shifted;
   logic [2*HGRP-1:0]   err_cat;
   assign cat     = {hi_data, lo_data};
   assign err_cat = {hi_err, lo_err};

   if (STAGED) begin : g_stages
      logic [CAT_BITS-1:0] stg [SH_W+1];
      assign stg[0] = cat;
      for (genvar s = 0; s < SH_W; s++) begin : g_s
         assign stg[s+1] = shift[s] ? (stg[s] >> (8 * (2 ** s))) : stg[s];
      end
      assign shifted = stg[SH_W];
   end else begin : g_flat
      assign shifted = cat >> {shift, 3'b000};
   end

   logic unused_top;
   assign unused_top = ^shifted[CAT_BITS-1:HALF_BITS];
   assign win        = shifted[HALF_BITS-1:0];

   // A group counts when any of its bytes falls inside the window.
   int cs;
   always_comb begin
      cs  = int'(shift);
      bad = 1'b0;
      for (int g = 0; g < 2 * HGRP; g++) begin
         if ((g * PAR_BYTES <= cs + HALF_BYTES - 1) && (g * PAR_BYTES + PAR_BYTES - 1 >= cs))
            bad = bad | err_cat[g];
      end
   end
endmodule

// File: rtl/sl_fetch_unit.sv
`timescale 1ns/1ps
module sl_fetch_unit
   import sl_fetch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 2,
   parameter int PAR_BYTES  = 8,
   parameter bit STAGED_ROT = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic                                    fetch_vld,
   input  logic [ADDR_W-1:0]                       fetch_addr,
   input  logic                                    fill_vld,
   input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    fill_line,
   input  logic [LINE_BYTES*8-1:0]                 fill_data,
   input  logic [LINE_BYTES/PAR_BYTES-1:0]         fill_par,
   input  logic                                    snp_vld,
   input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    snp_line,
   input  logic                                    snp_inv,
   output logic                                    win_vld,
   output logic                                    win_hit,
   output logic                                    win_perr,
   output logic [LINE_BYTES*4-1:0]                 win_data,
   output logic                                    snp_hit
);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(SETS);
   localparam int LA_W       = ADDR_W - OFF_W;
   localparam int TAG_W      = LA_W - IDX_W;
   localparam int HALF_BYTES = LINE_BYTES / 2;
   localparam int HALF_BITS  = HALF_BYTES * 8;
   localparam int NGRP       = LINE_BYTES / PAR_BYTES;
   localparam int HGRP       = NGRP / 2;
   localparam int SH_W       = OFF_W - 1;

   // Elaboration-time parameter checks.
   if (LINE_BYTES < 4 || (1 << OFF_W) != LINE_BYTES) begin : g_chk_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1 || WAYS > 2) begin : g_chk_ways
      $error("WAYS must be 1 or 2");
   end
   if (PAR_BYTES < 1 || (HALF_BYTES % PAR_BYTES) != 0) begin : g_chk_par
      $error("PAR_BYTES must divide half a line");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   // Address split.
   logic [LA_W-1:0]  cur_la, nxt_la;
   logic [OFF_W-1:0] off;
   logic             upper;
   logic [SH_W-1:0]  rot;
   logic             need_nxt;

   assign cur_la   = fetch_addr[ADDR_W-1:OFF_W];
   assign nxt_la   = cur_la + 1'b1;
   assign off      = fetch_addr[OFF_W-1:0];
   assign upper    = off[OFF_W-1];
   assign rot      = off[SH_W-1:0];
   assign need_nxt = upper && (rot != '0);

   // Tag lookups on three ports.
   logic [N_TAG_PORTS-1:0][IDX_W-1:0] lk_idx;
   logic [N_TAG_PORTS-1:0][TAG_W-1:0] lk_tag;
   tag_look_t [N_TAG_PORTS-1:0]       lk;

   assign lk_idx[TP_CUR] = cur_la[IDX_W-1:0];
   assign lk_tag[TP_CUR] = cur_la[LA_W-1:IDX_W];
   assign lk_idx[TP_NXT] = nxt_la[IDX_W-1:0];
   assign lk_tag[TP_NXT] = nxt_la[LA_W-1:IDX_W];
   assign lk_idx[TP_SNP] = snp_line[IDX_W-1:0];
   assign lk_tag[TP_SNP] = snp_line[LA_W-1:IDX_W];

   logic cur_hit, nxt_hit, snp_found;
   assign cur_hit   = lk[TP_CUR].hit;
   assign nxt_hit   = lk[TP_NXT].hit;
   assign snp_found = lk[TP_SNP].hit;

   logic                 lines_ok, used_bad, hit_now;
   logic                 fill_way;
   logic [1:0]           touch_en;
   logic [1:0][IDX_W-1:0] touch_idx;
   logic [1:0]           touch_way;

   assign touch_en[0]  = fetch_vld && hit_now;
   assign touch_en[1]  = fetch_vld && hit_now && need_nxt;
   assign touch_idx[0] = lk_idx[TP_CUR];
   assign touch_idx[1] = lk_idx[TP_NXT];
   assign touch_way[0] = lk[TP_CUR].way;
   assign touch_way[1] = lk[TP_NXT].way;

   sl_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst       (rst),
      .look_idx  (lk_idx),
      .look_tag  (lk_tag),
      .look      (lk),
      .fill_en   (fill_vld),
      .fill_idx  (fill_line[IDX_W-1:0]),
      .fill_tag  (fill_line[LA_W-1:IDX_W]),
      .fill_way  (fill_way),
      .inv_en    (snp_vld && snp_inv && snp_found),
      .inv_idx   (lk_idx[TP_SNP]),
      .inv_way   (lk[TP_SNP].way),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .touch_way (touch_way)
   );

   // Half-line reads: port 0 is the first half of the window, port 1 the second.
   logic [1:0][IDX_W-1:0]     rd_idx;
   logic [1:0]                rd_way, rd_half;
   logic [1:0][HALF_BITS-1:0] rd_data;
   logic [1:0][HGRP-1:0]      rd_err;

   assign rd_idx[0]  = lk_idx[TP_CUR];
   assign rd_way[0]  = lk[TP_CUR].way;
   assign rd_half[0] = upper;
   assign rd_idx[1]  = upper ? lk_idx[TP_NXT] : lk_idx[TP_CUR];
   assign rd_way[1]  = upper ? lk[TP_NXT].way : lk[TP_CUR].way;
   assign rd_half[1] = ~upper;

   sl_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .PAR_BYTES(PAR_BYTES)) u_store (
      .clk     (clk),
      .wr_en   (fill_vld),
      .wr_idx  (fill_line[IDX_W-1:0]),
      .wr_way  (fill_way),
      .wr_data (fill_data),
      .wr_par  (fill_par),
      .rd_idx  (rd_idx),
      .rd_way  (rd_way),
      .rd_half (rd_half),
      .rd_data (rd_data),
      .rd_err  (rd_err)
   );

   logic [HALF_BITS-1:0] win_now;

   sl_window_align #(.HALF_BYTES(HALF_BYTES), .PAR_BYTES(PAR_BYTES), .STAGED(STAGED_ROT)) u_align (
      .lo_data (rd_data[0]),
      .hi_data (rd_data[1]),
      .lo_err  (rd_err[0]),
      .hi_err  (rd_err[1]),
      .shift   (rot),
      .win     (win_now),
      .bad     (used_bad)
   );

   assign lines_ok = cur_hit && (!need_nxt || nxt_hit);
   assign hit_now  = lines_ok && !used_bad;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_vld  <= 1'b0;
         win_hit  <= 1'b0;
         win_perr <= 1'b0;
         win_data <= '0;
         snp_hit  <= 1'b0;
      end else begin
         win_vld  <= fetch_vld;
         win_hit  <= fetch_vld && hit_now;
         win_perr <= fetch_vld && lines_ok && used_bad;
         if (fetch_vld) win_data <= win_now;
         snp_hit  <= snp_vld && snp_found;
      end
   end
endmodule

// File: rtl/sl_fetch_unit_chk.sv
`timescale 1ns/1ps
module sl_fetch_unit_chk (
   input logic clk,
   input logic rst,
   input logic fetch_vld,
   input logic win_vld,
   input logic win_hit,
   input logic win_perr,
   input logic snp_vld,
   input logic snp_hit,
   input logic cur_hit,
   input logic nxt_hit,
   input logic need_nxt
);
   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
      fetch_vld |=> win_vld);

   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !fetch_vld |=> !win_vld);

   p_perr_excludes_hit_r6: assert property (@(posedge clk) disable iff (rst)
      win_perr |-> (win_vld && !win_hit));

   p_cur_miss_r4: assert property (@(posedge clk) disable iff (rst)
      (fetch_vld && !cur_hit) |=> !win_hit);

   p_straddle_miss_r5: assert property (@(posedge clk) disable iff (rst)
      (fetch_vld && need_nxt && !nxt_hit) |=> (!win_hit && !win_perr));

   p_snoop_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !snp_vld |=> !snp_hit);
endmodule

bind sl_fetch_unit sl_fetch_unit_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .fetch_vld (fetch_vld),
   .win_vld   (win_vld),
   .win_hit   (win_hit),
   .win_perr  (win_perr),
   .snp_vld   (snp_vld),
   .snp_hit   (snp_hit),
   .cur_hit   (cur_hit),
   .nxt_hit   (nxt_hit),
   .need_nxt  (need_nxt)
);

// File: tb/sl_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module sl_fetch_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         fetch_vld = 1'b0;
   logic [31:0]  fetch_addr = '0;
   logic         fill_vld = 1'b0;
   logic [26:0]  fill_line = '0;
   logic [255:0] fill_data = '0;
   logic [3:0]   fill_par = '0;
   logic         snp_vld = 1'b0;
   logic [26:0]  snp_line = '0;
   logic         snp_inv = 1'b0;
   logic         win_vld, win_hit, win_perr, snp_hit;
   logic [127:0] win_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0] addr;
      logic        hit;
      logic        perr;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   sl_fetch_unit dut_i (
      .clk(clk), .rst(rst),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .fill_vld(fill_vld), .fill_line(fill_line), .fill_data(fill_data), .fill_par(fill_par),
      .snp_vld(snp_vld), .snp_line(snp_line), .snp_inv(snp_inv),
      .win_vld(win_vld), .win_hit(win_hit), .win_perr(win_perr), .win_data(win_data),
      .snp_hit(snp_hit)
   );

   function automatic logic [7:0] code_byte(logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   // Monitor: pops one expected item per response.
   always @(negedge clk) begin
      exp_t e;
      logic [127:0] expd;
      if (!rst && win_vld) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2: response with no request, hit=%0b exp none", win_hit);
         end else begin
            e = exp_q.pop_front();
            for (int i = 0; i < 16; i++) expd[i*8 +: 8] = code_byte(e.addr + 32'(i));
            if (win_hit !== e.hit || win_perr !== e.perr || (e.hit && win_data !== expd)) begin
               fails++;
               $display("FAIL %s addr=%h: hit=%0b perr=%0b data=%h exp hit=%0b perr=%0b data=%h",
                        e.req, e.addr, win_hit, win_perr, win_data, e.hit, e.perr, expd);
            end
         end
      end
   end

   task automatic load_fill(input logic [31:0] base, input logic [3:0] bad);
      fill_vld  = 1'b1;
      fill_line = base[31:5];
      for (int i = 0; i < 32; i++) fill_data[i*8 +: 8] = code_byte({base[31:5], 5'd0} + 32'(i));
      for (int g = 0; g < 4; g++) fill_par[g] = (^fill_data[g*64 +: 64]) ^ bad[g];
   endtask

   task automatic do_fill(input logic [31:0] base, input logic [3:0] bad);
      @(negedge clk);
      load_fill(base, bad);
      @(negedge clk);
      fill_vld = 1'b0;
   endtask

   task automatic do_fetch(input logic [31:0] a, input logic hit, input logic perr, input string req);
      @(negedge clk);
      fetch_vld  = 1'b1;
      fetch_addr = a;
      exp_q.push_back('{addr: a, hit: hit, perr: perr, req: req});
      @(negedge clk);
      fetch_vld = 1'b0;
   endtask

   task automatic fill_with_fetch(input logic [31:0] base, input logic [31:0] a);
      @(negedge clk);
      load_fill(base, 4'b0000);
      fetch_vld  = 1'b1;
      fetch_addr = a;
      exp_q.push_back('{addr: a, hit: 1'b0, perr: 1'b0, req: "R9"});
      @(negedge clk);
      fill_vld  = 1'b0;
      fetch_vld = 1'b0;
   endtask

   task automatic do_snoop(input logic [31:0] a, input logic inv, input logic exp_hit);
      @(negedge clk);
      snp_vld  = 1'b1;
      snp_line = a[31:5];
      snp_inv  = inv;
      @(negedge clk);
      snp_vld = 1'b0;
      snp_inv = 1'b0;
      checks++;
      if (snp_hit !== exp_hit) begin
         fails++;
         $display("FAIL R8: snoop %h snp_hit=%0b exp %0b", a, snp_hit, exp_hit);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (win_vld !== 1'b0 || win_hit !== 1'b0 || win_perr !== 1'b0 || snp_hit !== 1'b0) begin
         fails++;
         $display("FAIL R1: outputs vld=%0b hit=%0b perr=%0b snp=%0b exp all 0",
                  win_vld, win_hit, win_perr, snp_hit);
      end
      do_fetch(32'h0000_0400, 1'b0, 1'b0, "R1");

      // R3/R4/R5: single-line and straddling windows
      do_fill(32'h0000_0400, 4'b0000);
      do_fill(32'h0000_0420, 4'b0000);
      do_fetch(32'h0000_0400, 1'b1, 1'b0, "R3");
      do_fetch(32'h0000_0405, 1'b1, 1'b0, "R3");
      do_fetch(32'h0000_0410, 1'b1, 1'b0, "R4");
      do_fetch(32'h0000_0411, 1'b1, 1'b0, "R5");
      do_fetch(32'h0000_0418, 1'b1, 1'b0, "R5");
      do_fetch(32'h0000_041F, 1'b1, 1'b0, "R5");
      do_fetch(32'h0000_0430, 1'b1, 1'b0, "R4");
      do_fetch(32'h0000_0431, 1'b0, 1'b0, "R5");
      do_fetch(32'h0000_043F, 1'b0, 1'b0, "R5");
      do_fetch(32'h0000_03F8, 1'b0, 1'b0, "R4");

      // R5: straddle from set 127 into set 0 with tag carry
      do_fill(32'h0000_0FE0, 4'b0000);
      do_fill(32'h0000_1000, 4'b0000);
      do_fetch(32'h0000_0FF4, 1'b1, 1'b0, "R5");
      do_fetch(32'h0000_0FE8, 1'b1, 1'b0, "R4");

      // R6: parity groups inside and outside the window
      do_fill(32'h0000_0800, 4'b1000);
      do_fetch(32'h0000_0800, 1'b1, 1'b0, "R6");
      do_fetch(32'h0000_0808, 1'b1, 1'b0, "R6");
      do_fetch(32'h0000_0809, 1'b0, 1'b1, "R6");
      do_fetch(32'h0000_0810, 1'b0, 1'b1, "R6");
      do_fill(32'h0000_0860, 4'b0000);
      do_fill(32'h0000_0880, 4'b0010);
      do_fetch(32'h0000_0878, 1'b1, 1'b0, "R6");
      do_fetch(32'h0000_087C, 1'b0, 1'b1, "R6");

      // R7: replacement order in set 0x10
      do_fill(32'h0000_0200, 4'b0000);
      do_fill(32'h0000_1200, 4'b0000);
      do_fetch(32'h0000_0200, 1'b1, 1'b0, "R7");
      do_fill(32'h0000_2200, 4'b0000);
      do_fetch(32'h0000_0200, 1'b1, 1'b0, "R7");
      do_fetch(32'h0000_1200, 1'b0, 1'b0, "R7");
      do_fetch(32'h0000_2200, 1'b1, 1'b0, "R7");

      // R9: fetch in the same cycle as its fill sees the old state
      fill_with_fetch(32'h0000_0600, 32'h0000_0604);
      do_fetch(32'h0000_0604, 1'b1, 1'b0, "R9");

      // R8: snoop lookup and invalidation
      do_snoop(32'h0000_0FE0, 1'b0, 1'b1);
      do_fetch(32'h0000_0FF4, 1'b1, 1'b0, "R8");
      do_snoop(32'h0000_0FE4, 1'b1, 1'b1);
      do_fetch(32'h0000_0FF4, 1'b0, 1'b0, "R8");
      do_snoop(32'h0000_0FE0, 1'b0, 1'b0);
      do_snoop(32'h0000_5000, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R2: %0d responses missing, exp 0", exp_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2: watchdog expired, done=0 exp 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule